// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device

This block is the memory side of a three-wire serial EEPROM link. A host raises chip select and clocks in a command one bit per serial clock rising edge. The command is a start bit, a two-bit opcode, an address and, for writes, a data word. The block holds a 128-byte array. A level on the organisation input selects how the array is seen: as 128 bytes, or as 64 sixteen-bit words. For a read, it shifts the addressed word out on its data output, most significant bit first. For a write, it holds the address and data until chip select falls. That edge starts a programming cycle timed by the system clock.

While programming runs, the data output reports status whenever chip select is high. It drives low while the array is busy and high once the cycle has finished. The host clears the ready indication either by clocking in a new start bit or by dropping chip select. Writes are only accepted after a write-enable command, and a write-disable command locks them out again.

All pins are asynchronous to the system clock. Each passes through a synchroniser, and the block acts on the detected edges of the serial clock and chip select.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is low the data output enable stays low, and serial clock or data-in activity leaves no trace on any later command.
- R2: A chip select rising edge restarts command decoding. Leading 0 bits are skipped and the first 1 sampled is the start bit. A command cut off by chip select falling has no effect.
- R3: The two bits after the start bit form the opcode, first bit most significant. 10 means read and 01 means write. 00 is a control opcode: if the top two address bits are 11 it enables writes, and if they are 00 it disables them. Writes are disabled after reset, and a write received while disabled changes nothing.
- R4: With the organisation input at 0 the array is 128 x 8 with a 7-bit address. With it at 1 the array is 64 x 16 with a 6-bit address. Sixteen-bit word w covers byte 2w (low half) and byte 2w+1 (high half). Addresses and data travel most significant bit first.
- R5: A read drives the data output right after the last address bit is sampled, starting with one 0 bit. Each following serial clock rising edge then presents the next data bit, most significant first. The rising edge after the last data bit releases the output.
- R6: Once a full write (start, opcode, address and all data bits) has been clocked in while writes are enabled, chip select falling stores the word and starts a programming cycle of PROG_CYCLES system clocks. The cycle does not depend on the serial clock. A write with missing data bits does not program.
- R7: While programming and chip select is high, the data output is driven low. After the cycle ends it is driven high while chip select is high. Toggling chip select during the cycle does not stop or restart it.
- R8: The ready indication is cleared by a start bit, which also opens a new command, or by chip select falling after the cycle has ended.
- R9: While a programming cycle runs, serial clock edges and data-in values are ignored, so no command is accepted.
- R10: After reset every byte of the array reads as 0x00 and the data output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| org_i | input | 1 | Organisation: 0 = bytes, 1 = 16-bit words |
| do_o | output | 1 | Serial data or status to the host |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
A pin change reaches the block's outputs SYNC_STAGES+1 system clocks after the clock edge that follows it: two synchroniser stages, then the registered state. The bench drives each pin phase for six clocks and compares the outputs with its model on every clock once five clocks have passed since its last pin change. A programming cycle ends PROG_CYCLES clocks after chip select falls, give or take the synchroniser delay, so the bench does not compare within a few cycles on either side of that point and does not drive the pins then either.

// File: rtl/mw_pkg.sv
package mw_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA,
      ST_DONE
   } mw_state_e;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_CTRL  = 2'b00;
   localparam logic [1:0] CTL_EN   = 2'b11;
   localparam logic [1:0] CTL_DIS  = 2'b00;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int NSIG   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSIG-1:0] pin_i,
   output logic [NSIG-1:0] lvl_o,
   output logic [NSIG-1:0] rise_o,
   output logic [NSIG-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mw_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < NSIG; i++) begin : g_sig
      logic [STAGES:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-1:0], pin_i[i]};
      end
      assign lvl_o[i]  = sh[STAGES-1];
      assign rise_o[i] = sh[STAGES-1] & ~sh[STAGES];
      assign fall_o[i] = ~sh[STAGES-1] & sh[STAGES];
   end
endmodule

// File: rtl/mw_mem.sv
module mw_mem
   import mw_pkg::*;
#(
   parameter int NBYTES = 128,
   localparam int AW    = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_i,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [WORD_W-1:0] rdata_o
);
   if (NBYTES < 8 || (1 << AW) != NBYTES) begin : g_bad_size
      $error("mw_mem: NBYTES must be a power of two, 8 or more");
   end

   logic [BYTE_W-1:0] arr [NBYTES];
   logic [AW-1:0]     w_lo, w_hi, r_lo, r_hi;

   always_comb begin
      w_lo = {waddr_i[AW-2:0], 1'b0};
      w_hi = {waddr_i[AW-2:0], 1'b1};
      r_lo = {raddr_i[AW-2:0], 1'b0};
      r_hi = {raddr_i[AW-2:0], 1'b1};
      if (wide_i) rdata_o = {arr[r_hi], arr[r_lo]};
      else        rdata_o = {arr[raddr_i], {BYTE_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NBYTES; k++) arr[k] <= '0;
      end else if (we_i) begin
         if (wide_i) begin
            arr[w_hi] <= wdata_i[WORD_W-1:BYTE_W];
            arr[w_lo] <= wdata_i[BYTE_W-1:0];
         end else begin
            arr[waddr_i] <= wdata_i[BYTE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/mw_prog.sv
module mw_prog #(
   parameter int PROG_CYCLES = 200,
   localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic cs_fall_i,
   input  logic start_bit_i,
   output logic busy_o,
   output logic show_o
);
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("mw_prog: PROG_CYCLES must be at least 1");
   end

   logic [CW-1:0] left;
   assign busy_o = (left != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left   <= '0;
         show_o <= 1'b0;
      end else if (start_i) begin
         left   <= CW'(PROG_CYCLES);
         show_o <= 1'b1;
      end else begin
         if (busy_o) left <= left - 1'b1;
         if (!busy_o && (start_bit_i || cs_fall_i)) show_o <= 1'b0;
      end
   end

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o); // R9
   AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> show_o); // R7
endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
   import mw_pkg::*;
#(
   parameter int AW  = 7,
   localparam int CW = $clog2(WORD_W + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl_i,
   input  logic              cs_rise_i,
   input  logic              cs_fall_i,
   input  logic              sk_rise_i,
   input  logic              di_i,
   input  logic              org_i,
   input  logic              busy_i,
   input  logic [WORD_W-1:0] rdata_i,
   output logic [AW-1:0]     raddr_o,
   output logic [AW-1:0]     waddr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              wide_o,
   output logic              prog_start_o,
   output logic              start_bit_o,
   output logic              rd_oe_o,
   output logic              rd_bit_o
);
   if (AW < 3) begin : g_bad_aw
      $error("mw_cmd: AW must be at least 3");
   end

   mw_state_e         state;
   logic [CW-1:0]     cnt, nab, ndw;
   logic [1:0]        op, ctl_top;
   logic [AW-1:0]     addr, addr_nx;
   logic [WORD_W-1:0] data, rsh;
   logic              wen, pend;
   logic              step;

   always_comb begin
      nab     = wide_o ? CW'(AW - 1) : CW'(AW);
      ndw     = wide_o ? CW'(WORD_W) : CW'(BYTE_W);
      addr_nx = {addr[AW-2:0], di_i};
      ctl_top = wide_o ? addr_nx[AW-2 -: 2] : addr_nx[AW-1 -: 2];
      step    = cs_lvl_i && sk_rise_i && !busy_i;
   end

   assign raddr_o      = addr_nx;
   assign waddr_o      = addr;
   assign wdata_o      = data;
   assign prog_start_o = cs_fall_i && pend && !busy_i;
   assign start_bit_o  = step && (state == ST_IDLE) && di_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; op <= '0; addr <= '0; data <= '0;
         rsh <= '0; wen <= 1'b0; pend <= 1'b0; wide_o <= 1'b0;
         rd_oe_o <= 1'b0; rd_bit_o <= 1'b0;
      end else if (cs_rise_i) begin
         state <= ST_IDLE; cnt <= '0; op <= '0; addr <= '0; data <= '0;
         rsh <= '0; pend <= 1'b0; wide_o <= org_i;
         rd_oe_o <= 1'b0; rd_bit_o <= 1'b0;
      end else if (!cs_lvl_i) begin
         state <= ST_IDLE;
         rd_oe_o <= 1'b0;
         if (cs_fall_i) pend <= 1'b0;
      end else if (step) begin
         unique case (state)
            ST_IDLE: if (di_i) begin
               state <= ST_OPC;
               cnt   <= '0;
            end
            ST_OPC: begin
               op  <= {op[0], di_i};
               cnt <= cnt + 1'b1;
               if (cnt == CW'(1)) begin
                  state <= ST_ADDR;
                  cnt   <= '0;
               end
            end
            ST_ADDR: begin
               addr <= addr_nx;
               cnt  <= cnt + 1'b1;
               if (cnt == nab - 1'b1) begin
                  cnt <= '0;
                  unique case (op)
                     OP_READ: begin
                        state    <= ST_RDATA;
                        rd_oe_o  <= 1'b1;
                        rd_bit_o <= 1'b0;
                        rsh      <= rdata_i;
                     end
                     OP_WRITE: state <= ST_WDATA;
                     OP_CTRL: begin
                        state <= ST_DONE;
                        if (ctl_top == CTL_EN)  wen <= 1'b1;
                        if (ctl_top == CTL_DIS) wen <= 1'b0;
                     end
                     default: state <= ST_DONE;
                  endcase
               end
            end
            ST_WDATA: begin
               data <= {data[WORD_W-2:0], di_i};
               cnt  <= cnt + 1'b1;
               if (cnt == ndw - 1'b1) begin
                  state <= ST_DONE;
                  pend  <= wen;
               end
            end
            ST_RDATA: begin
               rd_bit_o <= rsh[WORD_W-1];
               rsh      <= {rsh[WORD_W-2:0], 1'b0};
               cnt      <= cnt + 1'b1;
               if (cnt == ndw) begin
                  rd_oe_o  <= 1'b0;
                  rd_bit_o <= 1'b0;
                  state    <= ST_DONE;
               end
            end
            default: ;
         endcase
      end
   end

   AST_IDLE_WHEN_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_lvl_i |=> (state == ST_IDLE) && !rd_oe_o); // R1
   AST_DRIVE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_oe_o) |-> ($past(state) == ST_ADDR) && !rd_bit_o); // R5
   AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start_o |-> wen); // R3
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PROG_CYCLES = 200,
   parameter int MEM_BYTES   = 128,
   localparam int AW         = $clog2(MEM_BYTES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org_i,
   output logic do_o,
   output logic do_oe_o
);
   localparam int P_CS = 0, P_SK = 1, P_DI = 2, P_ORG = 3, NPIN = 4;

   logic [NPIN-1:0]   lvl, rise, fall;
   logic [AW-1:0]     raddr, waddr;
   logic [WORD_W-1:0] rdata, wdata;
   logic              wide, prog_start, start_bit, rd_oe, rd_bit, busy, show;

   mw_sync #(.NSIG(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .pin_i({org_i, di_i, sk_i, cs_i}),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   mw_cmd #(.AW(AW)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .cs_lvl_i(lvl[P_CS]), .cs_rise_i(rise[P_CS]), .cs_fall_i(fall[P_CS]),
      .sk_rise_i(rise[P_SK]), .di_i(lvl[P_DI]), .org_i(lvl[P_ORG]),
      .busy_i(busy), .rdata_i(rdata),
      .raddr_o(raddr), .waddr_o(waddr), .wdata_o(wdata), .wide_o(wide),
      .prog_start_o(prog_start), .start_bit_o(start_bit),
      .rd_oe_o(rd_oe), .rd_bit_o(rd_bit)
   );

   mw_mem #(.NBYTES(MEM_BYTES)) u_mem (
      .clk(clk), .rst_n(rst_n), .wide_i(wide), .we_i(prog_start),
      .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata)
   );

   mw_prog #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
      .clk(clk), .rst_n(rst_n), .start_i(prog_start),
      .cs_fall_i(fall[P_CS]), .start_bit_i(start_bit),
      .busy_o(busy), .show_o(show)
   );

   assign do_oe_o = lvl[P_CS] && (show || rd_oe);
   assign do_o    = do_oe_o && (show ? !busy : rd_bit);

   AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[P_CS] && busy) |-> (do_oe_o && !do_o)); // R7
   AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl[P_CS]) |=> !rd_oe); // R1
endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
   localparam int CLK_PERIOD = 10;
   localparam int PROG       = 100;
   localparam int HOLD       = 6;
   localparam int SETTLE     = 5;
   localparam int LIMIT      = 150000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0;
   logic do_o, do_oe;

   mw_eeprom #(.PROG_CYCLES(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
      .do_o(do_o), .do_oe_o(do_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    cyc = 0, since = 0, errors = 0, checks = 0;
   string req = "R10";

   // behavioural reference model
   byte unsigned mmem [128];
   bit  m_wen, m_started, m_reading, m_done, m_pend, m_show, m_rd_oe, m_rd_bit, m_org;
   bit  cmd_q[$];
   bit  rd_q[$];
   int  prog_t0 = -100000, pend_a, pend_d;

   function automatic bit m_busy();
      return (cyc - prog_t0) < PROG + 8;
   endfunction

   always @(posedge clk) begin cyc++; since++; end

   always @(negedge clk) begin
      int el;
      bit eoe, edo;
      el = cyc - prog_t0;
      if (rst_n && since >= SETTLE && !(el >= PROG - 2 && el <= PROG + 8)) begin
         eoe = cs && (m_show || m_rd_oe);
         edo = m_show ? !(el < PROG) : m_rd_bit;
         checks++;
         if (do_oe !== eoe || (eoe && do_o !== edo)) begin
            errors++;
            $display("FAIL %s cyc=%0d actual oe=%b do=%b expected oe=%b do=%b",
                     req, cyc, do_oe, do_o, eoe, edo);
         end
      end
   end

   task automatic hold(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic model_rise(bit b);
      int n, ab, dw, a, op, w;
      if (!cs || m_busy()) return;
      if (!m_started) begin
         if (b) begin m_started = 1; m_show = 0; end
         return;
      end
      if (m_reading) begin
         if (rd_q.size() > 0) m_rd_bit = rd_q.pop_front();
         else begin m_rd_oe = 0; m_rd_bit = 0; m_reading = 0; m_done = 1; end
         return;
      end
      if (m_done) return;
      cmd_q.push_back(b);
      n  = cmd_q.size();
      ab = m_org ? 6 : 7;
      dw = m_org ? 16 : 8;
      op = cmd_q[0] * 2 + cmd_q[1];
      a  = 0;
      if (n >= 2 + ab) for (int i = 0; i < ab; i++) a = a * 2 + cmd_q[2 + i];
      if (n == 2 + ab) begin
         if (op == 2) begin
            w = m_org ? (mmem[2*a+1] * 256 + mmem[2*a]) : mmem[a];
            for (int i = dw - 1; i >= 0; i--) rd_q.push_back(bit'((w >> i) & 1));
            m_rd_oe = 1; m_rd_bit = 0; m_reading = 1;
         end else if (op == 0) begin
            if (cmd_q[2] && cmd_q[3]) m_wen = 1;
            if (!cmd_q[2] && !cmd_q[3]) m_wen = 0;
            m_done = 1;
         end else if (op == 3) m_done = 1;
      end
      if (op == 1 && n == 2 + ab + dw) begin
         w = 0;
         for (int i = 0; i < dw; i++) w = w * 2 + cmd_q[2 + ab + i];
         if (m_wen) begin m_pend = 1; pend_a = a; pend_d = w; end
         m_done = 1;
      end
   endtask

   task automatic cs_up();
      @(negedge clk); cs = 1; sk = 0; di = 0; since = 0;
      m_started = 0; cmd_q.delete(); rd_q.delete();
      m_reading = 0; m_done = 0; m_pend = 0; m_rd_oe = 0; m_rd_bit = 0; m_org = org;
      hold(HOLD);
   endtask

   task automatic cs_down();
      @(negedge clk); cs = 0; sk = 0; di = 0; since = 0;
      m_rd_oe = 0; m_reading = 0;
      if (m_pend && !m_busy()) begin
         if (m_org) begin
            mmem[2*pend_a+1] = byte'(pend_d >> 8);
            mmem[2*pend_a]   = byte'(pend_d);
         end else mmem[pend_a] = byte'(pend_d);
         prog_t0 = cyc; m_show = 1;
      end else if (m_show && !m_busy()) m_show = 0;
      m_pend = 0;
      hold(HOLD);
   endtask

   task automatic send(int v, int nb);
      for (int i = nb - 1; i >= 0; i--) begin
         @(negedge clk); sk = 0; di = (v >> i) & 1; since = 0;
         hold(HOLD);
         @(negedge clk); sk = 1; since = 0;
         model_rise(di);
         hold(HOLD);
      end
   endtask

   task automatic do_read(int a);
      int ab = org ? 6 : 7, dw = org ? 16 : 8;
      send(1, 1); send(2, 2); send(a, ab); send(0, dw + 2);
   endtask

   task automatic do_write(int a, int d);
      int ab = org ? 6 : 7, dw = org ? 16 : 8;
      send(1, 1); send(1, 2); send(a, ab); send(d, dw);
   endtask

   task automatic do_ctrl(bit en);
      int ab = org ? 6 : 7;
      send(1, 1); send(0, 2); send(en ? 3 : 0, 2); send(0, ab - 2);
   endtask

   task automatic wait_prog();
      while ((cyc - prog_t0) < PROG + 12) hold(1);
   endtask

   initial begin
      hold(LIMIT);
      errors++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      foreach (mmem[i]) mmem[i] = 0;
      hold(3);
      checks++;
      if (do_oe !== 1'b0) begin
         errors++;
         $display("FAIL R10 reset actual oe=%b expected oe=0", do_oe);
      end
      @(negedge clk); rst_n = 1; since = 0;
      hold(HOLD);

      req = "R1";   // activity with chip select low is ignored
      send(1, 1); send(2, 2); send(5, 7); send(0, 4);
      hold(HOLD);

      req = "R3";   // write while disabled changes nothing; array starts at zero
      cs_up(); do_write(5, 8'hA5); cs_down();
      cs_up(); hold(HOLD); do_read(5); cs_down();

      cs_up(); do_ctrl(1); cs_down();

      req = "R6";   // enabled write programs on chip select fall
      cs_up(); do_write(5, 8'hA5); cs_down();
      req = "R7";   // status low while busy, chip select toggles harmless
      cs_up(); hold(HOLD); cs_down(); cs_up();
      req = "R9";   // command during programming ignored
      do_read(5);
      cs_down(); cs_up();
      wait_prog();
      req = "R7";
      hold(HOLD);
      req = "R8";   // start bit clears ready and opens a read
      do_read(5); cs_down();

      req = "R2";   // leading zeros before the start bit
      cs_up(); send(0, 3); do_read(5); cs_down();
      req = "R2";   // aborted read, then a clean one
      cs_up(); send(1, 1); send(2, 2); send(5, 7); send(0, 3); cs_down();
      cs_up(); do_read(5); cs_down();

      req = "R6";   // write with missing data bits does not program
      cs_up(); send(1, 1); send(1, 2); send(9, 7); send(3, 4); cs_down();
      cs_up(); hold(HOLD); do_read(9); cs_down();

      req = "R4";   // 16-bit organisation and its byte mapping
      org = 1; hold(HOLD);
      cs_up(); do_write(3, 16'h1234); cs_down();
      cs_up(); wait_prog(); hold(HOLD);
      req = "R8";   // chip select fall clears ready
      cs_down(); cs_up(); hold(HOLD);
      req = "R4";
      do_read(3); cs_down();
      org = 0; hold(HOLD);
      cs_up(); do_read(6); cs_down();
      cs_up(); do_read(7); cs_down();

      req = "R5";   // read frame of a byte: dummy 0, 8 bits, release
      cs_up(); do_read(5); cs_down();

      req = "R3";   // disable blocks writes
      cs_up(); do_ctrl(0); cs_down();
      cs_up(); do_write(5, 8'h3C); cs_down();
      cs_up(); hold(HOLD); do_read(5); cs_down();

      hold(HOLD);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule